// File: doc/BRIEF.md
# Carry-Resolving Byte Packer for an Arithmetic Encoder

This block sits behind the low-register stage of a binary arithmetic encoder. Each cycle that stage produces a group of 0 to 8 result bits. It can also produce a carry that adds one to everything encoded so far. The packer joins these groups into bytes. It then holds the most recent settled byte, together with any 0xFF bytes that follow it, until it is certain that no carry can still change them. It emits them as one group: a head byte, a run count, and a stuff flag that gives the value of the run bytes.

A carry can ripple through the trailing 0xFF bytes into the held head. The packer therefore never commits a byte that a carry could still change. When a carry reaches a pending run, the head is incremented and the run is released as zero bytes. At the end of a slice, a flush pads the partial byte with zeros and forces out everything still pending.

Top module: `carry_byte_packer`

## Requirements
- R1: After reset, `out_valid` stays low, no bits are buffered and no head byte is held.
- R2: When `in_valid` is high, the low `in_len` bits of `in_bits` are appended to the stream. The most significant of them comes first, and `in_len` never exceeds 8.
- R3: A completed byte is held and not emitted while no head byte is held. When a completed byte other than 0xFF arrives with a head held, the output registers show the head byte, the run count and stuff = 1 on the clock edge that accepts that input. The new byte then becomes the head.
- R4: A completed byte equal to 0xFF that follows a held head increments the run count and produces no output.
- R5: `in_carry` (with `in_valid`) adds one at the last bit accepted before this cycle's bits. It ripples through the partial byte and on into the completed bytes.
- R6: A carry that ripples into a pending run of n 0xFF bytes emits head+1 with stuff = 0, so the run bytes become 0x00. If a non-0xFF byte completes in the same cycle, the run count is n and that byte becomes the head. Otherwise the run count is n-1 and a 0x00 byte becomes the held head.
- R7: `flush` pads the partial byte with zeros and treats it as completed. The data and carry inputs are ignored in the flush cycle and the cycle after it. The held group is emitted with stuff = 1 on the following edge, and the next bits start a fresh stream.
- R8: Expanding every output group (head, then run copies of 0xFF for stuff = 1 or 0x00 for stuff = 0) gives exactly the byte stream produced by exact binary addition of all carries. This assumes carries never overflow a slice made only of one bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Bits and carry qualifier |
| in_bits | input | IN_W | Result bits, right-aligned |
| in_len | input | clog2(IN_W+1) | Number of valid bits, 0..IN_W |
| in_carry | input | 1 | Add one to the stream before appending |
| flush | input | 1 | End of slice: pad and drain |
| out_valid | output | 1 | An output group is present |
| out_byte | output | 8 | Head byte of the group |
| out_run | output | RUN_W | Number of run bytes after the head |
| out_stuff | output | 1 | Run byte value: 1 means 0xFF, 0 means 0x00 |

## Verification
The bench targets carries that ripple through a whole 0xFF run. A design that got this wrong would emit stale 0xFF bytes, or fail to increment the head. It also targets a carry that coincides with a newly completed byte, where a wrong split would drop or duplicate a 0x00 byte. Further cases are carries that land on a partial byte made only of ones or on an empty buffer, and flushes with a partial byte or an active run. These would expose missing padding, lost trailing runs, or flush-cycle data leaking into the stream. Every emitted group is expanded and compared against a byte array to which each carry has been applied by exact addition.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ONES_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DRAIN,
    ACT_CARRY_RUN,
    ACT_BYTE
  } settle_act_e;
endpackage

// File: rtl/cbp_accum.sv
module cbp_accum #(
  parameter int IN_W  = 8,
  parameter int LEN_W = 4,
  parameter int BUF_W = 15,
  parameter int CNT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic                      bump,
  input  logic                      flush_go,
  input  logic [IN_W-1:0]           bits,
  input  logic [LEN_W-1:0]          len,
  output logic                      ovf,
  output logic                      byte_vld,
  output logic [cbp_pkg::BYTE_W-1:0] byte_val,
  output logic [CNT_W-1:0]          cnt_out
);
  import cbp_pkg::*;

  logic [BUF_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BUF_W:0]   sum;
  logic [BUF_W-1:0] bumped, joined, shifted, padded;
  logic [IN_W-1:0]  in_mask;
  logic [CNT_W-1:0] total;
  logic             en;

  always_comb begin
    sum      = {1'b0, buf_q} + {{BUF_W{1'b0}}, 1'b1};
    ovf      = bump && sum[cnt_q];
    bumped   = bump ? (sum[BUF_W-1:0] & ~({BUF_W{1'b1}} << cnt_q)) : buf_q;
    in_mask  = ~({IN_W{1'b1}} << len);
    joined   = take ? ((bumped << len) | BUF_W'(bits & in_mask)) : bumped;
    total    = cnt_q + (take ? CNT_W'(len) : CNT_W'(0));
    padded   = buf_q << (CNT_W'(BYTE_W) - cnt_q);
    shifted  = joined >> (total - CNT_W'(BYTE_W));
    byte_vld = 1'b0;
    byte_val = '0;
    buf_d    = joined;
    cnt_d    = total;
    if (flush_go) begin
      byte_vld = (cnt_q != '0);
      byte_val = padded[BYTE_W-1:0];
      buf_d    = '0;
      cnt_d    = '0;
    end else if (total >= CNT_W'(BYTE_W)) begin
      byte_vld = 1'b1;
      byte_val = shifted[BYTE_W-1:0];
      cnt_d    = total - CNT_W'(BYTE_W);
      buf_d    = joined & ~({BUF_W{1'b1}} << cnt_d);
    end
  end

  assign en      = take | bump | flush_go;
  assign cnt_out = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cbp_settle.sv
module cbp_settle #(
  parameter int RUN_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       drain,
  input  logic                       ovf,
  input  logic                       byte_vld,
  input  logic [cbp_pkg::BYTE_W-1:0] byte_val,
  output logic                       held_out,
  output logic                       out_valid,
  output logic [cbp_pkg::BYTE_W-1:0] out_byte,
  output logic [RUN_W-1:0]           out_run,
  output logic                       out_stuff
);
  import cbp_pkg::*;

  logic [BYTE_W-1:0] head_q, head_d, base, e_byte;
  logic              held_q, held_d, emit, e_stuff;
  logic [RUN_W-1:0]  run_q, run_d, e_run;
  settle_act_e       act;

  always_comb begin
    if (drain)                        act = ACT_DRAIN;
    else if (ovf && run_q != '0)      act = ACT_CARRY_RUN;
    else if (byte_vld || ovf)         act = ACT_BYTE;
    else                              act = ACT_IDLE;
  end

  always_comb begin
    head_d  = head_q;
    held_d  = held_q;
    run_d   = run_q;
    emit    = 1'b0;
    e_byte  = head_q;
    e_run   = run_q;
    e_stuff = 1'b1;
    base    = ovf ? head_q + 8'd1 : head_q;
    unique case (act)
      ACT_DRAIN: begin
        emit   = held_q;
        held_d = byte_vld;
        head_d = byte_val;
        run_d  = '0;
      end
      ACT_CARRY_RUN: begin
        emit    = 1'b1;
        e_byte  = head_q + 8'd1;
        e_stuff = 1'b0;
        held_d  = 1'b1;
        if (byte_vld && byte_val != ONES_BYTE) begin
          e_run  = run_q;
          head_d = byte_val;
          run_d  = '0;
        end else begin
          e_run  = run_q - RUN_W'(1);
          head_d = '0;
          run_d  = byte_vld ? RUN_W'(1) : '0;
        end
      end
      ACT_BYTE: begin
        head_d = base;
        if (byte_vld) begin
          if (!held_q) begin
            held_d = 1'b1;
            head_d = byte_val;
          end else if (byte_val == ONES_BYTE) begin
            run_d = run_q + RUN_W'(1);
          end else begin
            emit   = 1'b1;
            e_byte = base;
            head_d = byte_val;
            run_d  = '0;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      held_q <= 1'b0;
      run_q  <= '0;
    end else begin
      head_q <= head_d;
      held_q <= held_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_run   <= '0;
      out_stuff <= 1'b1;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_byte  <= e_byte;
        out_run   <= e_run;
        out_stuff <= e_stuff;
      end
    end
  end

  assign held_out = held_q;
endmodule

// File: rtl/carry_byte_packer.sv
module carry_byte_packer #(
  parameter int IN_W  = 8,
  parameter int RUN_W = 8,
  localparam int LEN_W = $clog2(IN_W + 1),
  localparam int BUF_W = IN_W + 7,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_bits,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_carry,
  input  logic             flush,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic [RUN_W-1:0] out_run,
  output logic             out_stuff
);
  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             drain_q, flush_go, take, bump;
  logic             ovf, byte_vld, held;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign flush_go = flush & ~drain_q;
  assign take     = in_valid & ~flush_go & ~drain_q;
  assign bump     = take & in_carry;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) drain_q <= 1'b0;
    else          drain_q <= flush_go;
  end

  cbp_accum #(.IN_W(IN_W), .LEN_W(LEN_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_q_n), .take(take), .bump(bump), .flush_go(flush_go),
    .bits(in_bits), .len(in_len), .ovf(ovf), .byte_vld(byte_vld),
    .byte_val(byte_val), .cnt_out(acc_cnt)
  );

  cbp_settle #(.RUN_W(RUN_W)) u_set (
    .clk(clk), .rst_n(rst_q_n), .drain(drain_q), .ovf(ovf),
    .byte_vld(byte_vld), .byte_val(byte_val), .held_out(held),
    .out_valid(out_valid), .out_byte(out_byte), .out_run(out_run),
    .out_stuff(out_stuff)
  );
endmodule

module carry_byte_packer_chk #(
  parameter int IN_W  = 8,
  parameter int LEN_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [LEN_W-1:0] in_len,
  input logic             flush_go,
  input logic             drain_q,
  input logic [CNT_W-1:0] acc_cnt,
  input logic             byte_vld,
  input logic [7:0]       byte_val,
  input logic             ovf,
  input logic             held,
  input logic             out_valid,
  input logic [7:0]       out_byte,
  input logic             out_stuff
);
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_len <= LEN_W'(IN_W));

  a_r3_settle_emits: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && held && byte_val != 8'hFF && !drain_q |=> out_valid);

  a_r4_run_silent: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && byte_val == 8'hFF && held && !ovf && !drain_q |=> !out_valid);

  a_r6_carried_head: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_stuff |-> out_byte != 8'h00);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> acc_cnt == '0);

  a_r7_drain_out: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q && held |=> out_valid && out_stuff);
endmodule

bind carry_byte_packer carry_byte_packer_chk #(.IN_W(IN_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .in_len(in_len),
  .flush_go(flush_go), .drain_q(drain_q), .acc_cnt(acc_cnt),
  .byte_vld(byte_vld), .byte_val(byte_val), .ovf(ovf), .held(held),
  .out_valid(out_valid), .out_byte(out_byte), .out_stuff(out_stuff)
);

// File: tb/carry_byte_packer_test.sv
module carry_byte_packer_test;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_bits;
  logic [3:0] in_len;
  logic       in_carry;
  logic       flush;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [7:0] out_run;
  logic       out_stuff;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] ref_q[$];
  int rd_ptr = 0;
  int slice_start = 0;
  int part_v = 0;
  int part_n = 0;

  carry_byte_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_len(in_len), .in_carry(in_carry), .flush(flush), .out_valid(out_valid),
    .out_byte(out_byte), .out_run(out_run), .out_stuff(out_stuff)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic report(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit carry_legal();
    if (part_n > 0 && part_v != (1 << part_n) - 1) return 1;
    for (int i = slice_start; i < ref_q.size(); i++)
      if (ref_q[i] != 8'hFF) return 1;
    return 0;
  endfunction

  task automatic ref_carry();
    if (part_n > 0 && part_v != (1 << part_n) - 1) begin
      part_v++;
    end else begin
      int i;
      part_v = 0;
      i = ref_q.size() - 1;
      while (ref_q[i] == 8'hFF) begin
        ref_q[i] = 8'h00;
        i--;
      end
      ref_q[i] = ref_q[i] + 8'd1;
    end
  endtask

  task automatic ref_append(int bits, int len);
    part_v = (part_v << len) | (bits & ((1 << len) - 1));
    part_n += len;
    if (part_n >= 8) begin
      ref_q.push_back(8'((part_v >> (part_n - 8)) & 255));
      part_n -= 8;
      part_v &= (1 << part_n) - 1;
    end
  endtask

  // Compare any group present now against the reference stream (R8, R4, R6, R3)
  task automatic monitor();
    string tag;
    if (!out_valid) return;
    tag = !out_stuff ? "R6" : (out_run != 0 ? "R4" : "R3");
    if (rd_ptr >= ref_q.size()) begin
      report("R8", "head beyond stream", int'(out_byte), -1);
      return;
    end
    report(tag, "head byte", int'(out_byte), int'(ref_q[rd_ptr]));
    rd_ptr++;
    for (int k = 0; k < int'(out_run); k++) begin
      if (rd_ptr >= ref_q.size()) begin
        report("R8", "run beyond stream", k, -1);
        return;
      end
      report(tag, "run byte", out_stuff ? 255 : 0, int'(ref_q[rd_ptr]));
      rd_ptr++;
    end
  endtask

  task automatic step(bit v, int bits, int len, bit c, bit f);
    in_valid = v; in_bits = 8'(bits); in_len = 4'(len); in_carry = c; flush = f;
    if (f) begin
      if (part_n > 0) ref_q.push_back(8'((part_v << (8 - part_n)) & 255));
      part_v = 0; part_n = 0;
      slice_start = ref_q.size();
    end else if (v) begin
      if (c) ref_carry();
      ref_append(bits, len);
    end
    @(negedge clk);
    monitor();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 200000, 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_bits = 0; in_len = 0; in_carry = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    report("R1", "out_valid after reset", int'(out_valid), 0);

    // R2: 101 then 00110 forms A6; R3: held, no output yet
    step(1, 3'b101, 3, 0, 0);
    step(1, 5'b00110, 5, 0, 0);
    report("R3", "held byte not emitted", int'(out_valid), 0);
    step(1, 8'h34, 8, 0, 0);
    report("R2", "packed byte", int'(out_byte), 8'hA6);
    report("R3", "valid on settle", int'(out_valid), 1);
    // R4: two 0xFF bytes after held 0x34 stay silent
    step(1, 8'hFF, 8, 0, 0);
    report("R4", "ff no output", int'(out_valid), 0);
    step(1, 8'hFF, 8, 0, 0);
    report("R4", "ff no output", int'(out_valid), 0);
    // R6: carry on empty buffer ripples into run: 35, run 1, stuff 0
    step(1, 0, 0, 1, 0);
    report("R6", "carried head", int'(out_byte), 8'h35);
    report("R6", "carried run", int'(out_run), 1);
    report("R6", "carried stuff", int'(out_stuff), 0);
    // R7: 1010 then flush with data ignored
    step(1, 4'b1010, 4, 0, 0);
    step(1, 8'hFF, 8, 0, 1);
    report("R7", "flush emits held 00", int'(out_byte), 8'h00);
    step(0, 0, 0, 0, 0);
    report("R7", "drain emits padded", int'(out_byte), 8'hA0);
    report("R7", "drain stuff", int'(out_stuff), 1);
    // R5: carry into partial 0011 -> 0100, then 0000 -> 0x40
    step(1, 4'b0011, 4, 0, 0);
    step(1, 4'b0000, 4, 1, 0);
    step(1, 8'h10, 8, 0, 0);
    report("R5", "carry into partial", int'(out_byte), 8'h40);

    for (int s = 0; s < 5; s++) begin
      for (int n = 0; n < 3000; n++) begin
        int len, bits;
        bit v, c;
        v = ($urandom_range(0, 99) < 85);
        len = $urandom_range(0, 8);
        bits = ($urandom_range(0, 99) < 45) ? 255 : int'($urandom_range(0, 255));
        c = v && ($urandom_range(0, 99) < 12) && carry_legal();
        step(v, bits, len, c, 0);
      end
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      report("R7", "slice fully drained", rd_ptr, ref_q.size());
    end
    report("R8", "total bytes", rd_ptr, ref_q.size());
    finish_run();
  end
endmodule